// File: doc/BRIEF.md
# Flash ECC Syndrome Checker

This block compares the error-correcting code computed over each 256-byte chunk of a flash page with the code read back from the spare area, and then sorts the result into one of four classes. The classes are: nothing wrong, a damaged code field, a single data bit that can be repaired, or damage that cannot be repaired. When a data bit can be repaired, the block also reports which byte of the chunk holds it and which bit of that byte to invert. The block does not touch the data buffer. A software or DMA agent applies the flip from the reported address.

Each chunk code is 22 bits wide and is carried in three little-endian bytes. The low 11 bits are the line/column parity, and bits 21:11 hold its complement parity. A page step of 512 bytes is handled by decoding two chunks side by side: the second chunk takes code bytes 3 to 5. The per-chunk failures are then merged into one failure flag. A single start pulse samples both code buses, and all results appear in registers on the next clock edge.

Top module: `nfc_ecc_check`

## Requirements
- R1: While reset is asserted, and until the first start is sampled, `done_o` and `fail_o` are 0 and all classes and fix addresses are 0.
- R2: `done_o` is 1 in exactly the cycle after a clock edge at which `start_i` was 1, and 0 otherwise. Class, address and fail outputs change only at such edges and hold their values between them.
- R3: Chunk c takes its code from bytes 3c, 3c+1 and 3c+2 of each code bus, assembled as byte0 | byte1<<8 | byte2<<16, keeping bits 21:0. Bits 7:6 of the third byte have no effect. The class of chunk c appears at `class_o[2c+1:2c]`, its byte address at `fix_byte_o[8c+7:8c]` and its bit address at `fix_bit_o[3c+2:3c]`.
- R4: If the syndrome (computed XOR stored) is zero, or either code is all zeros, the class is 0 (clean). This rule takes priority over every other rule.
- R5: Otherwise, if exactly one syndrome bit is set, the class is 1 (code field damaged).
- R6: Otherwise, if exactly 11 syndrome bits are set and syndrome[10:0] XOR syndrome[21:11] equals 0x7FF, the class is 2 (repairable). The byte address is syndrome[10:3] and the bit address is syndrome[2:0].
- R7: Every other syndrome gives class 3 (unrepairable).
- R8: For any class other than 2, the byte and bit addresses of that chunk are 0.
- R9: `fail_o` is 1 when any chunk has class 1 or class 3, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sample both code buses and decode |
| calc_code_i | input | 48 | Computed code bytes, byte k at bits 8k+7:8k |
| stored_code_i | input | 48 | Code bytes read from the spare area, same layout |
| done_o | output | 1 | One-cycle pulse marking fresh results |
| fail_o | output | 1 | Some chunk has class 1 or class 3 |
| class_o | output | 4 | Two bits per chunk: 0 clean, 1 code field, 2 repairable, 3 unrepairable |
| fix_byte_o | output | 16 | Byte address to repair, 8 bits per chunk |
| fix_bit_o | output | 6 | Bit address to repair, 3 bits per chunk |

## Verification
The assertions assume that the code buses carry valid values only in the cycle that `start_i` is high. Between starts, the buses are free to change without effect, and the bench moves them on purpose to test that. The assertions also assume that reset holds `start_i` low, so the first `done_o` can only follow a start. The bench builds each repairable stimulus as a stored code XOR a syndrome of the form {~a, a}. Every other stimulus has a syndrome chosen so that its bit count and half-XOR fall into one known class, including one where the all-zero rule must override a single-bit syndrome.

// File: rtl/nfc_ecc_pkg.sv
package nfc_ecc_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN     = 2'd0,
        ECC_FIELD_ERR = 2'd1,
        ECC_FIXABLE   = 2'd2,
        ECC_FATAL     = 2'd3
    } ecc_class_e;

endpackage

// File: rtl/nfc_ecc_popcnt.sv
module nfc_ecc_popcnt #(
    parameter int W  = 22,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/nfc_ecc_chunk_dec.sv
module nfc_ecc_chunk_dec
    import nfc_ecc_pkg::*;
#(
    parameter int PARITY_W = 11,
    localparam int CODE_W = 2 * PARITY_W,
    localparam int BYTE_W = PARITY_W - 3,
    localparam int CW     = $clog2(CODE_W + 1)
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output ecc_class_e        class_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [2:0]        bit_o
);
    logic [CODE_W-1:0]   syn;
    logic [PARITY_W-1:0] half_mix;
    logic [CW-1:0]       ones;

    assign syn      = calc_i ^ stored_i;
    assign half_mix = syn[PARITY_W-1:0] ^ syn[CODE_W-1:PARITY_W];

    nfc_ecc_popcnt #(.W(CODE_W)) u_pop (
        .vec_i   (syn),
        .count_o (ones)
    );

    always_comb begin
        class_o = ECC_CLEAN;
        byte_o  = '0;
        bit_o   = '0;
        if (syn == '0 || calc_i == '0 || stored_i == '0) begin
            class_o = ECC_CLEAN;
        end else if (ones == CW'(1)) begin
            class_o = ECC_FIELD_ERR;
        end else if (ones == CW'(PARITY_W) && half_mix == '1) begin
            class_o = ECC_FIXABLE;
            byte_o  = syn[PARITY_W-1:3];
            bit_o   = syn[2:0];
        end else begin
            class_o = ECC_FATAL;
        end
    end
endmodule

// File: rtl/nfc_ecc_check.sv
module nfc_ecc_check
    import nfc_ecc_pkg::*;
#(
    parameter int NUM_CHUNKS = 2,
    parameter int PARITY_W   = 11,
    localparam int CODE_W     = 2 * PARITY_W,
    localparam int CODE_BYTES = (CODE_W + 7) / 8,
    localparam int LANE_W     = CODE_BYTES * 8,
    localparam int BYTE_W     = PARITY_W - 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [NUM_CHUNKS*LANE_W-1:0] calc_code_i,
    input  logic [NUM_CHUNKS*LANE_W-1:0] stored_code_i,
    output logic                         done_o,
    output logic                         fail_o,
    output logic [NUM_CHUNKS*2-1:0]      class_o,
    output logic [NUM_CHUNKS*BYTE_W-1:0] fix_byte_o,
    output logic [NUM_CHUNKS*3-1:0]      fix_bit_o
);
    typedef struct packed {
        logic                         done;
        logic                         fail;
        logic [NUM_CHUNKS*2-1:0]      cls;
        logic [NUM_CHUNKS*BYTE_W-1:0] byt;
        logic [NUM_CHUNKS*3-1:0]      bpos;
    } res_t;

    res_t res_d, res_q;

    ecc_class_e  dec_cls  [NUM_CHUNKS];
    logic [BYTE_W-1:0] dec_byte [NUM_CHUNKS];
    logic [2:0]        dec_bit  [NUM_CHUNKS];

    for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
        nfc_ecc_chunk_dec #(.PARITY_W(PARITY_W)) u_dec (
            .calc_i   (calc_code_i[c*LANE_W +: CODE_W]),
            .stored_i (stored_code_i[c*LANE_W +: CODE_W]),
            .class_o  (dec_cls[c]),
            .byte_o   (dec_byte[c]),
            .bit_o    (dec_bit[c])
        );
    end

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (start_i) begin
            res_d.done = 1'b1;
            res_d.fail = 1'b0;
            for (int c = 0; c < NUM_CHUNKS; c++) begin
                res_d.cls[c*2 +: 2]       = dec_cls[c];
                res_d.byt[c*BYTE_W +: BYTE_W] = dec_byte[c];
                res_d.bpos[c*3 +: 3]      = dec_bit[c];
                if (dec_cls[c] == ECC_FIELD_ERR || dec_cls[c] == ECC_FATAL) begin
                    res_d.fail = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign done_o     = res_q.done;
    assign fail_o     = res_q.fail;
    assign class_o    = res_q.cls;
    assign fix_byte_o = res_q.byt;
    assign fix_bit_o  = res_q.bpos;
endmodule

// File: rtl/nfc_ecc_check_sva.sv
module nfc_ecc_check_sva #(
    parameter int NUM_CHUNKS = 2,
    parameter int PARITY_W   = 11,
    localparam int CODE_W     = 2 * PARITY_W,
    localparam int LANE_W     = ((CODE_W + 7) / 8) * 8,
    localparam int BYTE_W     = PARITY_W - 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start_i,
    input logic [NUM_CHUNKS*LANE_W-1:0] calc_code_i,
    input logic [NUM_CHUNKS*LANE_W-1:0] stored_code_i,
    input logic                         done_o,
    input logic                         fail_o,
    input logic [NUM_CHUNKS*2-1:0]      class_o,
    input logic [NUM_CHUNKS*BYTE_W-1:0] fix_byte_o,
    input logic [NUM_CHUNKS*3-1:0]      fix_bit_o
);
    assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_done_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i));

    assert_results_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(class_o) && $stable(fix_byte_o)
                      && $stable(fix_bit_o) && $stable(fail_o)));

    logic any_odd;
    always_comb begin
        any_odd = 1'b0;
        for (int c = 0; c < NUM_CHUNKS; c++) any_odd = any_odd | class_o[c*2];
    end

    assert_fail_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> any_odd);

    for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chk
        assert_equal_codes_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && calc_code_i[c*LANE_W +: CODE_W] == stored_code_i[c*LANE_W +: CODE_W])
            |=> class_o[c*2 +: 2] == 2'd0);

        assert_zero_code_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && calc_code_i[c*LANE_W +: CODE_W] == '0)
            |=> class_o[c*2 +: 2] == 2'd0);

        assert_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            class_o[c*2 +: 2] != 2'd2
            |-> (fix_byte_o[c*BYTE_W +: BYTE_W] == '0 && fix_bit_o[c*3 +: 3] == '0));
    end
endmodule

bind nfc_ecc_check nfc_ecc_check_sva #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .PARITY_W   (PARITY_W)
) u_sva (.*);

// File: tb/test_nfc_ecc_check.sv
module test_nfc_ecc_check;

    typedef struct packed {
        logic [21:0] calc;
        logic [21:0] stored;
        logic [1:0]  cls;
        logic [7:0]  byt;
        logic [2:0]  bpos;
    } vec_t;

    localparam int NV = 11;
    // rows: clean equal, calc zero, stored zero, zero-overrides-one-bit,
    // one-bit code field, repairable x3, unrepairable x3
    localparam vec_t VECS [NV] = '{
        '{22'h012345, 22'h012345, 2'd0, 8'h00, 3'd0},
        '{22'h000000, 22'h000003, 2'd0, 8'h00, 3'd0},
        '{22'h00001F, 22'h000000, 2'd0, 8'h00, 3'd0},
        '{22'h000000, 22'h000010, 2'd0, 8'h00, 3'd0},
        '{22'h155555 ^ 22'h000400, 22'h155555, 2'd1, 8'h00, 3'd0},
        '{22'h0ABCDE ^ 22'h2AD2A5, 22'h0ABCDE, 2'd2, 8'h54, 3'd5},
        '{22'h000ABC ^ 22'h3FF800, 22'h000ABC, 2'd2, 8'h00, 3'd0},
        '{22'h100000 ^ 22'h0007FF, 22'h100000, 2'd2, 8'hFF, 3'd7},
        '{22'h2F0F0F ^ 22'h000003, 22'h2F0F0F, 2'd3, 8'h00, 3'd0},
        '{22'h033333 ^ 22'h000BFF, 22'h033333, 2'd3, 8'h00, 3'd0},
        '{22'h155555 ^ 22'h3FF801, 22'h155555, 2'd3, 8'h00, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] calc_code_i = '0;
    logic [47:0] stored_code_i = '0;
    logic        done_o, fail_o;
    logic [3:0]  class_o;
    logic [15:0] fix_byte_o;
    logic [5:0]  fix_bit_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nfc_ecc_check i_nfc_ecc_check (
        .clk, .rst_n, .start_i, .calc_code_i, .stored_code_i,
        .done_o, .fail_o, .class_o, .fix_byte_o, .fix_bit_o
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit is_fail(input logic [1:0] c);
        return c == 2'd1 || c == 2'd3;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // apply one decode and check both chunks in the cycle after the start edge
    task automatic run_pair(input vec_t v0, input vec_t v1, input logic [1:0] junk);
        logic exp_fail;
        @(negedge clk);
        start_i       = 1'b1;
        calc_code_i   = {2'b00, v1.calc, junk, v0.calc};
        stored_code_i = {junk, v1.stored, 2'b00, v0.stored};
        @(negedge clk);
        start_i       = 1'b0;
        exp_fail = is_fail(v0.cls) | is_fail(v1.cls);
        chk(done_o == 1'b1, "R2 done pulse", done_o, 1);
        chk(class_o[1:0] == v0.cls, "R4/R5/R6/R7 class chunk0", class_o[1:0], v0.cls);
        chk(class_o[3:2] == v1.cls, "R3 class chunk1", class_o[3:2], v1.cls);
        chk(fix_byte_o[7:0] == v0.byt && fix_bit_o[2:0] == v0.bpos, "R6/R8 addr chunk0",
            {fix_byte_o[7:0], fix_bit_o[2:0]}, {v0.byt, v0.bpos});
        chk(fix_byte_o[15:8] == v1.byt && fix_bit_o[5:3] == v1.bpos, "R3/R8 addr chunk1",
            {fix_byte_o[15:8], fix_bit_o[5:3]}, {v1.byt, v1.bpos});
        chk(fail_o == exp_fail, "R9 fail flag", fail_o, exp_fail);
        // move inputs without a start: nothing may change
        calc_code_i   = ~calc_code_i;
        stored_code_i = 48'h0;
        @(negedge clk);
        chk(done_o == 1'b0, "R2 done drops", done_o, 0);
        chk(class_o == {v1.cls, v0.cls}, "R2 class holds", class_o, {v1.cls, v0.cls});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o == 0 && fail_o == 0, "R1 reset flags", {done_o, fail_o}, 0);
        chk(class_o == 0 && fix_byte_o == 0 && fix_bit_o == 0, "R1 reset results",
            class_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 0 && class_o == 0, "R1 idle after reset", {done_o, class_o}, 0);

        for (int i = 0; i < NV; i++) begin
            run_pair(VECS[i], VECS[(i + 4) % NV], (i % 2 == 1) ? 2'b11 : 2'b00);
        end

        // R3: junk only in ignored bits, both chunks otherwise equal -> clean
        run_pair(VECS[0], VECS[0], 2'b11);
        // R3: lane placement, repairable in chunk1 only, clean in chunk0
        run_pair(VECS[0], VECS[7], 2'b00);
        // R5/R9: code field damage only in chunk1 still raises fail
        run_pair(VECS[6], VECS[4], 2'b00);

        // R2: back-to-back starts, second result lands the next cycle
        @(negedge clk);
        start_i       = 1'b1;
        calc_code_i   = {2'b00, VECS[8].calc, 2'b00, VECS[8].calc};
        stored_code_i = {2'b00, VECS[8].stored, 2'b00, VECS[8].stored};
        @(negedge clk);
        calc_code_i   = {2'b00, VECS[5].calc, 2'b00, VECS[5].calc};
        stored_code_i = {2'b00, VECS[5].stored, 2'b00, VECS[5].stored};
        chk(class_o == 4'hF && done_o, "R2 first of pair", class_o, 4'hF);
        @(negedge clk);
        start_i = 1'b0;
        chk(class_o == 4'hA && done_o && !fail_o, "R2 second of pair", class_o, 4'hA);
        chk(fix_byte_o == 16'h5454 && fix_bit_o == 6'o55, "R6 second of pair addr",
            fix_byte_o, 16'h5454);

        // R1: reset clears held results
        rst_n = 1'b0;
        @(negedge clk);
        chk(class_o == 0 && fix_byte_o == 0 && !done_o, "R1 reset clears", class_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule